// File: doc/BRIEF.md
# Eight-Bit Timer and Event Counter

This block holds an 8-bit up-counter that a small controller core uses either as an interval timer or as an event counter. In timer mode the count advances once every `PRE_DIV` clock cycles, using a prescaler that a timer start command resets. In event mode the count advances on each high-to-low transition of the external `t1_pin`. The pin is sampled once per cycle and is assumed to be synchronised upstream. A stop command freezes the count in either mode. The core can load the count directly at any time and can read it at any time.

When the count wraps from its all-ones value to zero, a timer flag is set. The flag is set whether or not the interrupt is enabled. A separate enable bit decides whether the same wrap also latches a pending interrupt request. That request stays high until `irq_ack` is asserted. The core reads the flag with a test command, and the test also clears the flag. The core drives one command per cycle on `op`, as its instruction decoder would. Interrupt vectoring is done outside this block.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, `count` is 0, `irq` is 0, the timer flag is clear, interrupts are disabled and the counter is stopped.
- R2: Op 3'd1 (start timer) resets the prescaler and selects clock counting. The first increment is seen `PRE_DIV` cycles after the cycle that carried the command. Each further increment follows `PRE_DIV` cycles after the previous one.
- R3: Op 3'd2 (start event) selects pin counting. `count` rises by one for each cycle in which `t1_pin` is 0 and its sample from the previous cycle was 1. Rising edges and steady levels do not change `count`.
- R4: Op 3'd3 (stop) freezes `count` in both modes, whatever `t1_pin` and the clock do. No cycle that carries op 3'd1, 3'd2 or 3'd3 produces a count step.
- R5: Op 3'd4 (load) places `load_val` on `count` after the next clock edge. A step that falls due in the same cycle is dropped. The prescaler phase is kept, so the next timer step stays on its original cycle.
- R6: A step from the all-ones value to 0 sets the timer flag, whether interrupts are enabled or not.
- R7: In a cycle that carries op 3'd7 (test), `tst_flag` shows the timer flag and the flag is then cleared. If a wrap happens in that same cycle, the flag is set again.
- R8: After op 3'd5 (enable interrupt), a wrap raises `irq` one cycle later. `irq` stays high until a cycle with `irq_ack` high. If a wrap and an acknowledge fall in the same cycle, the wrap wins.
- R9: After op 3'd6 (disable interrupt), a wrap does not raise `irq`. Disabling does not clear a request that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Command code for this cycle (0 = none) |
| load_val | input | CNT_W | Value written by the load command |
| t1_pin | input | 1 | External event input, already synchronised |
| irq_ack | input | 1 | Clears the pending interrupt request |
| count | output | CNT_W | Current count |
| tst_flag | output | 1 | Timer flag as seen by a test command this cycle |
| irq | output | 1 | Latched timer interrupt request |

## Verification
The assertions take for granted that `op` carries at most one command per cycle, and that `t1_pin` is a clean synchronous level that changes only between clock edges. The stimulus drives every input one step after the falling clock edge, so each value is held across a full rising edge. The stimulus also lines up wraps with tests, acknowledges and mode changes only on purpose. This lets the same-cycle priority rules be exercised one at a time while the reference model tracks every cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_GO_TIMER = 3'd1,
        OP_GO_EVENT = 3'd2,
        OP_HALT     = 3'd3,
        OP_LOAD     = 3'd4,
        OP_IRQ_ON   = 3'd5,
        OP_IRQ_OFF  = 3'd6,
        OP_TEST     = 3'd7
    } tmr_op_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_CLOCK = 2'd1,
        SRC_PIN   = 2'd2
    } tmr_src_e;

    typedef struct packed {
        logic tf;
        logic ie;
        logic pend;
    } tmr_flags_t;

    // Commands that change the count source drop any step in their cycle
    function automatic logic blocks_step(tmr_op_e code);
        return (code == OP_GO_TIMER) || (code == OP_GO_EVENT) || (code == OP_HALT);
    endfunction

endpackage

// File: rtl/evt_prescale.sv
module evt_prescale #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick = run && !clr && (phase_q == LAST);
endmodule

// File: rtl/evt_fall_det.sv
module evt_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= pin;
    end

    assign fall = last_q && !pin;
endmodule

// File: rtl/evt_count.sv
module evt_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst)       value_q <= '0;
        else if (load) value_q <= load_val;
        else if (step) value_q <= value_q + 1'b1;
    end

    assign value = value_q;
    assign wrap  = step && !load && (value_q == TOP);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRE_DIV = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [CNT_W-1:0] load_val,
    input  logic             t1_pin,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count,
    output logic             tst_flag,
    output logic             irq
);
    tmr_op_e    op_e;
    tmr_src_e   src_q;
    tmr_flags_t flags_q, flags_d;
    logic       pre_tick, pin_fall, step, wrap_w;
    logic       tf_w, ie_w;

    assign op_e = tmr_op_e'(op);

    evt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (src_q == SRC_CLOCK),
        .clr  (op_e == OP_GO_TIMER),
        .tick (pre_tick)
    );

    evt_fall_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (t1_pin),
        .fall (pin_fall)
    );

    always_comb begin
        step = 1'b0;
        if (!blocks_step(op_e)) begin
            case (src_q)
                SRC_CLOCK: step = pre_tick;
                SRC_PIN:   step = pin_fall;
                default:   step = 1'b0;
            endcase
        end
    end

    evt_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .load     (op_e == OP_LOAD),
        .load_val (load_val),
        .value    (count),
        .wrap     (wrap_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_NONE;
        end else begin
            case (op_e)
                OP_GO_TIMER: src_q <= SRC_CLOCK;
                OP_GO_EVENT: src_q <= SRC_PIN;
                OP_HALT:     src_q <= SRC_NONE;
                default:     src_q <= src_q;
            endcase
        end
    end

    always_comb begin
        flags_d = flags_q;
        if (op_e == OP_TEST) flags_d.tf = 1'b0;
        if (wrap_w)          flags_d.tf = 1'b1;
        if (op_e == OP_IRQ_ON)       flags_d.ie = 1'b1;
        else if (op_e == OP_IRQ_OFF) flags_d.ie = 1'b0;
        if (wrap_w && flags_q.ie) flags_d.pend = 1'b1;
        else if (irq_ack)         flags_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign tf_w     = flags_q.tf;
    assign ie_w     = flags_q.ie;
    assign tst_flag = (op_e == OP_TEST) && flags_q.tf;
    assign irq      = flags_q.pend;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op,
    input logic [CNT_W-1:0] load_val,
    input logic             irq_ack,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             wrap,
    input logic             tf,
    input logic             ie,
    input tmr_src_e         src
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !irq && !tf));

    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LOAD) |=> (count == $past(count) || count == $past(count) + 1'b1));

    p_halted_r4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_NONE && op != OP_LOAD) |=> $stable(count));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (count == $past(load_val)));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> tf);

    p_test_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TEST && !wrap) |=> !tf);

    p_irq_latched_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wrap && ie));

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        (!ie && !irq) |=> !irq);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (load_val),
    .irq_ack  (irq_ack),
    .count    (count),
    .irq      (irq),
    .wrap     (wrap_w),
    .tf       (tf_w),
    .ie       (ie_w),
    .src      (src_q)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
    localparam int DIV = 32;
    localparam int MAXV = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op = 3'd0;
    logic [7:0] load_val = 8'd0;
    logic       t1_pin = 1'b1;
    logic       irq_ack = 1'b0;
    logic [7:0] count;
    logic       tst_flag;
    logic       irq;

    evt_timer #(.CNT_W(8), .PRE_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .op(op), .load_val(load_val), .t1_pin(t1_pin),
        .irq_ack(irq_ack), .count(count), .tst_flag(tst_flag), .irq(irq)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    int    wd = 0;
    string tag = "R1";
    int    got_tst = 0;

    // Reference state
    int m_cnt, m_pre, m_src, m_tf, m_ie, m_pend, m_pin;

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog expired: got %0d cycles expected under 20000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input int got, input int exp, input string what);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic cycle(input int code, input int lv = 0, input bit pin = 1'b1, input bit ack = 1'b0);
        bit fall, blocked, ptick, step, ov;
        op = code[2:0];
        load_val = lv[7:0];
        t1_pin = pin;
        irq_ack = ack;
        #1;
        got_tst = int'(tst_flag);
        chk(got_tst, (code == 7 && m_tf != 0) ? 1 : 0, "tst_flag");
        fall    = (m_pin == 1) && !pin;
        blocked = (code == 1) || (code == 2) || (code == 3);
        ptick   = 1'b0;
        if (code == 1) m_pre = 0;
        else if (m_src == 1) begin
            if (m_pre == DIV - 1) begin ptick = 1'b1; m_pre = 0; end
            else m_pre = m_pre + 1;
        end
        step = !blocked && ((m_src == 1 && ptick) || (m_src == 2 && fall));
        ov = 1'b0;
        if (code == 4) m_cnt = lv;
        else if (step) begin
            if (m_cnt == MAXV) begin ov = 1'b1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        if (code == 7) m_tf = 0;
        if (ov) m_tf = 1;
        if (ov && m_ie != 0) m_pend = 1;
        else if (ack) m_pend = 0;
        if (code == 5) m_ie = 1;
        else if (code == 6) m_ie = 0;
        if (code == 1) m_src = 1;
        else if (code == 2) m_src = 2;
        else if (code == 3) m_src = 0;
        m_pin = pin ? 1 : 0;
        @(posedge clk);
        @(negedge clk);
        chk(int'(count), m_cnt, "count");
        chk(int'(irq), m_pend, "irq");
    endtask

    initial begin
        m_cnt = 0; m_pre = 0; m_src = 0; m_tf = 0; m_ie = 0; m_pend = 0; m_pin = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag = "R1";
        chk(int'(count), 0, "reset count");
        chk(int'(irq), 0, "reset irq");
        cycle(7);
        chk(got_tst, 0, "reset flag");

        // R2: prescaled timer
        tag = "R2";
        cycle(1);
        repeat (DIV - 1) cycle(0);
        chk(int'(count), 0, "before first tick");
        cycle(0);
        chk(int'(count), 1, "first tick");
        repeat (2 * DIV) cycle(0);
        chk(int'(count), 3, "tick spacing");

        // R5: load mid-phase keeps prescaler phase
        tag = "R5";
        repeat (10) cycle(0);
        cycle(4, 8'h10);
        repeat (20) cycle(0);
        chk(int'(count), 16, "loaded value held");
        cycle(0);
        chk(int'(count), 17, "phase kept");

        // R6 / R8: wrap with interrupt enabled
        tag = "R8";
        cycle(5);
        cycle(4, 8'hFE);
        repeat (70) cycle(0);
        chk(int'(irq), 1, "irq after wrap");
        repeat (5) cycle(0);
        chk(int'(irq), 1, "irq held");
        tag = "R7";
        cycle(7);
        chk(got_tst, 1, "test sees flag");
        cycle(7);
        chk(got_tst, 0, "flag cleared by test");
        tag = "R8";
        cycle(0, 0, 1'b1, 1'b1);
        chk(int'(irq), 0, "ack clears");

        // R9 / R6: wrap with interrupt disabled
        tag = "R9";
        cycle(6);
        cycle(4, 8'hFF);
        repeat (40) cycle(0);
        chk(int'(irq), 0, "no irq when disabled");
        tag = "R6";
        cycle(7);
        chk(got_tst, 1, "flag set while disabled");

        // R3: pin counting
        tag = "R3";
        cycle(2);
        cycle(4, 0);
        for (int i = 0; i < 10; i++) begin
            repeat ((i % 3) + 1) cycle(0, 0, 1'b0);
            repeat ((i % 2) + 1) cycle(0, 0, 1'b1);
        end
        chk(int'(count), 10, "falling edges counted");

        // R4: halt in both modes
        tag = "R4";
        cycle(3);
        for (int i = 0; i < 10; i++) begin
            cycle(0, 0, 1'b0);
            cycle(0, 0, 1'b1);
        end
        chk(int'(count), 10, "halted pin mode");
        cycle(1);
        cycle(3);
        repeat (3 * DIV) cycle(0);
        chk(int'(count), 10, "halted timer mode");

        // R7: wrap in the same cycle as a test
        tag = "R7";
        cycle(2);
        cycle(4, 8'hFF);
        cycle(7);
        cycle(7, 0, 1'b0);
        chk(got_tst, 0, "test before wrap");
        cycle(7, 0, 1'b1);
        chk(got_tst, 1, "wrap beats clear");

        // R8 / R9: wrap beats ack; disable keeps pending
        tag = "R8";
        cycle(5);
        cycle(4, 8'hFE);
        cycle(0, 0, 1'b0);
        cycle(0, 0, 1'b1);
        cycle(0, 0, 1'b0);
        chk(int'(irq), 1, "irq from pin wrap");
        cycle(4, 8'hFF);
        cycle(0, 0, 1'b1);
        cycle(0, 0, 1'b0, 1'b1);
        chk(int'(irq), 1, "wrap beats ack");
        tag = "R9";
        cycle(6);
        chk(int'(irq), 1, "disable keeps pending");
        cycle(0, 0, 1'b1, 1'b1);
        chk(int'(irq), 0, "ack after disable");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule